// File: doc/BRIEF.md
# Gateable Clock Divider with Staged Ratio Commit

This block makes the clock for one clock domain out of a faster reference clock. The reference may come from a PLL or straight from an oscillator. A divider value is presented on an input bus. It is captured into a staging register only when an update strobe is given. The running ratio then changes at the next output period boundary, so the output never shows a period that is partly old ratio and partly new. A `locked` flag falls as soon as an update is accepted. It rises again once the new ratio has produced one complete output period.

An enable input gates the output clock. Gate changes are timed so that every pulse that reaches the output has full width. A domain reset request is forwarded to a reset output. That output stays asserted for a programmable number of output periods after the request goes away, so the domain leaves reset aligned to its own clock.

Two build-time switches remove the enable gating or the whole rate path (staging, update and lock). With the rate path removed, the block runs at a fixed default ratio.

Top module: `clkdiv_domain`

## Requirements
- R1: Changing `div_val` without a `div_load` strobe leaves the output waveform and `locked` unchanged. A strobe captures `div_val` in the clock edge that samples it.
- R2: With an applied ratio N of 2 or more, `clk_out` has a period of N input cycles. It is high for floor(N/2) cycles and low for the remaining cycles.
- R3: With an applied ratio of 0 or 1, `clk_out` follows `clk_in` while enabled: high in the high phase of `clk_in`, low in its low phase.
- R4: `locked` is low in the cycle after a `div_load` strobe is sampled. It rises only after the new ratio has been applied at a period boundary and one full period at that ratio has ended. Without a further strobe, it then stays high.
- R5: A strobe that arrives while an earlier value is still waiting to be applied replaces the waiting value. The latest value is the one applied.
- R6: With `en` low, `clk_out` stays low. The gate opens and closes only while the divided clock is low, so every high pulse on `clk_out` is a full floor(N/2) cycles long.
- R7: `dom_rst_out` goes high in the cycle after `dom_rst_req` is sampled high. It stays high while the request is held and for `RST_HOLD` output periods after the request is released, then falls.
- R8: While `rst` is high, `clk_out` is low, `locked` is low and `dom_rst_out` is high.
- R9: With `HAS_GATE`=0 the output is never gated. With `HAS_RATE`=0 the ratio is fixed at `DEF_DIV`, `locked` is always high, and `div_val`/`div_load` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Reference clock to be divided |
| rst | input | 1 | Synchronous active-high block reset |
| div_val | input | DIV_W | Requested divider ratio (0 and 1 mean bypass) |
| div_load | input | 1 | Update strobe that stages `div_val` for application |
| en | input | 1 | Output clock enable |
| dom_rst_req | input | 1 | Domain reset request |
| clk_out | output | 1 | Divided and gated domain clock |
| locked | output | 1 | High when the output runs steadily at the last requested ratio |
| dom_rst_out | output | 1 | Reset for the clocked domain |

## Verification
A corrupted phase counter or applied ratio shows up within one output period as a pulse or gap of the wrong width on `clk_out`. The bench measures high and low run lengths after every change of ratio. A staging or lock fault appears as `locked` rising early, never rising, or a measured period that matches an older value than the last one strobed. A gate that moves at the wrong time leaves a shortened high pulse, which the run-length monitor catches on the first enable toggle. A reset-hold fault shifts the fall of `dom_rst_out` by whole output periods.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  // Ratios below two collapse to a straight pass of the reference.
  function automatic int unsigned eff_ratio(input int unsigned raw);
    return (raw <= 1) ? 1 : raw;
  endfunction
endpackage

// File: rtl/clkdiv_stage.sv
`timescale 1ns/1ps
module clkdiv_stage #(
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             div_load,
  input  logic             wrap,
  output logic             commit,
  output logic [DIV_W-1:0] staged,
  output logic             locked
);
  logic pending;
  logic settling;

  // Apply only at a boundary where no newer value arrives together with it.
  assign commit = pending & wrap & ~div_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      settling <= 1'b1;
      staged   <= DIV_W'(DEF_DIV);
      locked   <= 1'b0;
    end else if (div_load) begin
      staged   <= div_val;
      pending  <= 1'b1;
      settling <= 1'b0;
      locked   <= 1'b0;
    end else if (pending && wrap) begin
      pending  <= 1'b0;
      settling <= 1'b1;
      locked   <= 1'b0;
    end else if (settling && wrap) begin
      settling <= 1'b0;
      locked   <= 1'b1;
    end else begin
      locked   <= ~(pending | settling);
    end
  end
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core #(
  parameter int DIV_W   = 8,
  parameter int DEF_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [DIV_W-1:0] new_ratio,
  output logic             wrap,
  output logic             div_q,
  output logic             div_next_low,
  output logic             bypass
);
  import clkdiv_pkg::*;

  localparam logic [DIV_W-1:0] RST_RATIO = DIV_W'(eff_ratio(DEF_DIV));

  logic [DIV_W-1:0] act;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] act_nx;
  logic [DIV_W-1:0] cnt_nx;
  logic             div_d;

  assign wrap   = (cnt == act - 1'b1);
  assign bypass = (act == DIV_W'(1));

  always_comb begin
    act_nx = commit ? DIV_W'(eff_ratio(int'(new_ratio))) : act;
    if (commit || wrap) cnt_nx = '0;
    else                cnt_nx = cnt + 1'b1;
    div_d = (cnt_nx < (act_nx >> 1));
  end

  assign div_next_low = ~div_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      act   <= RST_RATIO;
      cnt   <= RST_RATIO - 1'b1;
      div_q <= 1'b0;
    end else begin
      act   <= act_nx;
      cnt   <= cnt_nx;
      div_q <= div_d;
    end
  end
endmodule

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate #(
  parameter bit HAS_GATE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic div_q,
  input  logic div_next_low,
  input  logic bypass,
  output logic gate_open,
  output logic clk_out
);
  generate
    if (HAS_GATE) begin : g_gate
      logic gate_q;
      logic gate_n;
      // Divided path: gate follows en only on edges that leave div_q low.
      always_ff @(posedge clk) begin
        if (rst)                        gate_q <= 1'b0;
        else if (bypass || div_next_low) gate_q <= en;
      end
      // Bypass path: gate moves while the reference clock is low.
      always_ff @(negedge clk) begin
        if (rst) gate_n <= 1'b0;
        else     gate_n <= en;
      end
      assign gate_open = gate_q;
      assign clk_out   = bypass ? (clk & gate_n) : (div_q & gate_q);
    end else begin : g_nogate
      logic unused_en;
      assign unused_en = en ^ div_next_low ^ rst;
      assign gate_open = 1'b1;
      assign clk_out   = bypass ? clk : div_q;
    end
  endgenerate
endmodule

// File: rtl/clkdiv_rsthold.sv
`timescale 1ns/1ps
module clkdiv_rsthold #(
  parameter int RST_HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic wrap,
  output logic rst_out
);
  localparam int CW = $clog2(RST_HOLD + 1) + 1;

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst || req) begin
      left    <= CW'(RST_HOLD);
      rst_out <= 1'b1;
    end else begin
      if (wrap && left != '0) left <= left - 1'b1;
      rst_out <= (left != '0);
    end
  end
endmodule

// File: rtl/clkdiv_domain.sv
`timescale 1ns/1ps
module clkdiv_domain #(
  parameter int DIV_W    = 8,
  parameter int DEF_DIV  = 4,
  parameter int RST_HOLD = 4,
  parameter bit HAS_GATE = 1'b1,
  parameter bit HAS_RATE = 1'b1
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             div_load,
  input  logic             en,
  input  logic             dom_rst_req,
  output logic             clk_out,
  output logic             locked,
  output logic             dom_rst_out
);
  logic             wrap;
  logic             commit;
  logic [DIV_W-1:0] staged;
  logic             div_q;
  logic             div_next_low;
  logic             bypass;
  logic             gate_open;

  generate
    if (HAS_RATE) begin : g_rate
      clkdiv_stage #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_stage (
        .clk(clk_in), .rst(rst), .div_val(div_val), .div_load(div_load),
        .wrap(wrap), .commit(commit), .staged(staged), .locked(locked)
      );
    end else begin : g_fixed
      logic unused_rate;
      assign unused_rate = ^div_val ^ div_load;
      assign commit = 1'b0;
      assign staged = DIV_W'(DEF_DIV);
      assign locked = 1'b1;
    end
  endgenerate

  clkdiv_core #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_core (
    .clk(clk_in), .rst(rst), .commit(commit), .new_ratio(staged),
    .wrap(wrap), .div_q(div_q), .div_next_low(div_next_low), .bypass(bypass)
  );

  clkdiv_gate #(.HAS_GATE(HAS_GATE)) u_gate (
    .clk(clk_in), .rst(rst), .en(en), .div_q(div_q),
    .div_next_low(div_next_low), .bypass(bypass),
    .gate_open(gate_open), .clk_out(clk_out)
  );

  clkdiv_rsthold #(.RST_HOLD(RST_HOLD)) u_rhold (
    .clk(clk_in), .rst(rst), .req(dom_rst_req), .wrap(wrap),
    .rst_out(dom_rst_out)
  );
endmodule

// File: rtl/clkdiv_domain_chk.sv
`timescale 1ns/1ps
module clkdiv_domain_chk #(
  parameter bit HAS_RATE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic div_load,
  input logic locked,
  input logic dom_rst_req,
  input logic dom_rst_out,
  input logic div_q,
  input logic gate_open
);
  // R4
  lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (HAS_RATE && div_load) |=> !locked);

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !div_load) |=> locked);

  // R6
  gate_open_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_open) |-> !div_q);

  // R6
  gate_close_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_open) |-> !div_q);

  // R7
  dom_rst_follow_chk: assert property (@(posedge clk) disable iff (rst)
    dom_rst_req |=> dom_rst_out);
endmodule

bind clkdiv_domain clkdiv_domain_chk #(.HAS_RATE(HAS_RATE)) u_chk (
  .clk(clk_in), .rst(rst), .div_load(div_load), .locked(locked),
  .dom_rst_req(dom_rst_req), .dom_rst_out(dom_rst_out),
  .div_q(div_q), .gate_open(gate_open)
);

// File: tb/clkdiv_domain_test.sv
`timescale 1ns/1ps
module clkdiv_domain_test;
  localparam int DIV_W = 8;

  logic             clk_in = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] div_val = '0;
  logic             div_load = 1'b0;
  logic             en = 1'b0;
  logic             dom_rst_req = 1'b0;
  logic             clk_out, locked, dom_rst_out;
  logic             clk_out2, locked2, dom_rst_out2;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk_in = ~clk_in;

  clkdiv_domain #(.DIV_W(DIV_W), .DEF_DIV(4), .RST_HOLD(4)) uut (
    .clk_in(clk_in), .rst(rst), .div_val(div_val), .div_load(div_load),
    .en(en), .dom_rst_req(dom_rst_req), .clk_out(clk_out),
    .locked(locked), .dom_rst_out(dom_rst_out)
  );

  clkdiv_domain #(.DIV_W(DIV_W), .DEF_DIV(3), .RST_HOLD(2),
                  .HAS_GATE(1'b0), .HAS_RATE(1'b0)) uut2 (
    .clk_in(clk_in), .rst(rst), .div_val(div_val), .div_load(div_load),
    .en(en), .dom_rst_req(dom_rst_req), .clk_out(clk_out2),
    .locked(locked2), .dom_rst_out(dom_rst_out2)
  );

  task automatic tick();
    @(posedge clk_in); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input bit which);
    return which ? clk_out2 : clk_out;
  endfunction

  task automatic measure(input bit which, output int hi, output int lo);
    int g;
    hi = 0; lo = 0;
    g = 0; while (pick(which) !== 1'b0 && g < 100) begin tick(); g++; end
    g = 0; while (pick(which) !== 1'b1 && g < 100) begin tick(); g++; end
    while (pick(which) === 1'b1 && hi < 100) begin tick(); hi++; end
    while (pick(which) === 1'b0 && lo < 100) begin tick(); lo++; end
  endtask

  task automatic wait_lock(input string req);
    int g = 0;
    while (locked !== 1'b1 && g < 200) begin tick(); g++; end
    chk(locked === 1'b1, req, int'(locked), 1);
  endtask

  task automatic load(input int v);
    div_val = DIV_W'(v); div_load = 1'b1;
    tick();
    div_load = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1;
    repeat (3) tick();
    chk(clk_out === 1'b0, "R8 clk_out", int'(clk_out), 0);
    chk(locked === 1'b0, "R8 locked", int'(locked), 0);
    chk(dom_rst_out === 1'b1, "R8 dom_rst_out", int'(dom_rst_out), 1);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_default();
    int hi, lo;
    wait_lock("R4 lock after reset");
    measure(0, hi, lo);
    chk(hi == 2, "R2 ratio4 high", hi, 2);
    chk(lo == 2, "R2 ratio4 low", lo, 2);
  endtask

  task automatic t_no_strobe();
    int hi, lo;
    div_val = 8'd6;
    repeat (20) tick();
    chk(locked === 1'b1, "R1 locked kept", int'(locked), 1);
    measure(0, hi, lo);
    chk(hi == 2 && lo == 2, "R1 period kept", hi + lo, 4);
  endtask

  task automatic t_ratio(input int v, input int ehi, input int elo, input string req);
    int hi, lo;
    load(v);
    chk(locked === 1'b0, "R4 lock drop", int'(locked), 0);
    wait_lock("R4 relock");
    measure(0, hi, lo);
    chk(hi == ehi, {req, " high"}, hi, ehi);
    chk(lo == elo, {req, " low"}, lo, elo);
  endtask

  task automatic t_bypass(input int v);
    load(v);
    wait_lock("R4 relock bypass");
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_in); #2;
      chk(clk_out === 1'b1, "R3 high phase", int'(clk_out), 1);
      @(negedge clk_in); #2;
      chk(clk_out === 1'b0, "R3 low phase", int'(clk_out), 0);
    end
    tick();
  endtask

  task automatic t_latest();
    int hi, lo;
    div_val = 8'd6; div_load = 1'b1; tick();
    div_val = 8'd10; tick();
    div_load = 1'b0;
    wait_lock("R5 relock");
    measure(0, hi, lo);
    chk(hi == 5 && lo == 5, "R5 latest wins", hi + lo, 10);
  endtask

  task automatic t_gate();
    int run = 0;
    int pulses = 0;
    bit armed = 0;
    bit stuck = 0;
    load(6);
    wait_lock("R4 relock 6");
    en = 1'b0;
    repeat (12) tick();
    for (int i = 0; i < 20; i++) begin
      if (clk_out !== 1'b0) stuck = 1;
      tick();
    end
    chk(!stuck, "R6 gated low", int'(stuck), 0);
    for (int i = 0; i < 240; i++) begin
      if (i % 7 == 0) en = ~en;
      tick();
      if (clk_out === 1'b1) begin
        if (armed) run++;
      end else begin
        if (armed && run > 0) begin
          pulses++;
          chk(run == 3, "R6 full pulse", run, 3);
        end
        armed = 1; run = 0;
      end
    end
    chk(pulses > 3, "R6 pulses seen", pulses, 4);
    en = 1'b1;
    repeat (6) tick();
  endtask

  task automatic t_domrst();
    dom_rst_req = 1'b1;
    tick();
    chk(dom_rst_out === 1'b1, "R7 assert", int'(dom_rst_out), 1);
    tick(); tick();
    chk(dom_rst_out === 1'b1, "R7 held", int'(dom_rst_out), 1);
    dom_rst_req = 1'b0;
    repeat (18) tick();
    chk(dom_rst_out === 1'b1, "R7 hold window", int'(dom_rst_out), 1);
    repeat (14) tick();
    chk(dom_rst_out === 1'b0, "R7 release", int'(dom_rst_out), 0);
  endtask

  task automatic t_variant();
    int hi, lo;
    en = 1'b0;
    load(7);
    chk(locked2 === 1'b1, "R9 lock const", int'(locked2), 1);
    measure(1, hi, lo);
    chk(hi == 1 && lo == 2, "R9 fixed ratio ungated", hi * 10 + lo, 12);
    en = 1'b1;
  endtask

  initial begin
    t_reset();
    t_default();
    t_no_strobe();
    t_ratio(5, 2, 3, "R2 ratio5");
    t_ratio(8, 4, 4, "R2 ratio8");
    t_bypass(1);
    t_bypass(0);
    t_latest();
    t_gate();
    t_domrst();
    t_variant();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule